// File: doc/BRIEF.md
# Transmit Word Queue with Status Flags

This block is the sixteen-entry staging queue between a processor bus and a serial card data path. The bus side pushes words into the queue with a write strobe. A parallel-load shift register in the data path takes the words from the queue one at a time. A registered output always presents the word at the head of the queue. When the data path has captured that word, it pulses `advance`, and the next word appears on the output one clock later.

The queue exports five status flags: full, empty, data-available, half-empty and a sticky underrun flag. The half-empty flag is intended to drive a DMA request line. An underrun is recorded when the data path asks for the next word while it is actively sending and the queue has nothing left. The flag stays set until a clear strobe arrives.

Deasserting the enable forces every flag low, empties the queue and clears the underrun record.

Top module: `txfifo_top`

## Requirements
- R1: The queue holds up to DEPTH (default 16) words and hands them out in the order they were written.
- R2: `outWord` is registered. One clock edge after a write into an empty queue, it shows that word. One edge after an `advance` pulse that consumes a word, it shows the next word. A write and an `advance` on the same edge are both honoured.
- R3: `fullFlag` is high exactly when all DEPTH entries hold data. A write while full is dropped and changes neither the stored words nor the pointers.
- R4: While enabled, `emptyFlag` is high exactly when no entry holds data, and `dataAvail` is always its inverse.
- R5: While enabled, `halfEmptyFlag` is high whenever at least DEPTH/2 entries are free. With the default depth, that means 8 or fewer words are stored.
- R6: `underrunFlag` becomes set one edge after `advance` coincides with `txActive` high and an empty queue. It stays set until `clrUnderrun` is high on an edge. If set and clear arrive on the same edge, set takes priority. `advance` on an empty queue with `txActive` low does not set it.
- R7: While `fifoEn` is low, all five flags are low, writes are ignored, both pointers return to zero and the underrun record is cleared. After re-enabling, the queue is empty.
- R8: An `advance` pulse on an empty queue does not move the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | Queue enable; low flushes the queue and silences the flags |
| wrEn | input | 1 | Bus write strobe, pushes `wrData` |
| wrData | input | DATA_W | Word to push |
| advance | input | 1 | Pulse from the data path after it has loaded its shift register |
| txActive | input | 1 | High while the data path is transmitting |
| clrUnderrun | input | 1 | Clears the sticky underrun flag |
| outWord | output | DATA_W | Registered head-of-queue word |
| fullFlag | output | 1 | All entries occupied |
| emptyFlag | output | 1 | No entry occupied |
| halfEmptyFlag | output | 1 | At least half the entries free (DMA request) |
| dataAvail | output | 1 | Inverse of empty while enabled |
| underrunFlag | output | 1 | Sticky underrun record |

## Verification
The bench targets the following corner cases:

- **Half-empty boundary.** It fills the queue to exactly eight and then nine words. A design with an off-by-one in the free-space comparison would request DMA one word too early or too late.
- **Write into a full queue.** It pushes an extra word into a full queue and then drains it. An implementation that accepted the write would overwrite the oldest entry, and the drained order would show the corruption.
- **Underrun priority and exceptions.** It applies an underrun together with a clear, and it also advances an empty queue while idle. A design that let the clear win would lose the event, and one that ignored `txActive` would raise a false flag.
- **Disable and re-enable.** It disables a partially filled queue and then re-enables it. If the pointers were kept, stale words would reappear at the output.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;

  // Strobes from the control unit to the storage datapath
  typedef struct packed {
    logic doWrite;   // store the bus word at the write pointer
    logic doRead;    // head word consumed by the shift register
    logic flush;     // queue disabled, pointers forced to zero
  } fifoStrobe_t;

endpackage

// File: rtl/txfifo_ctrl.sv
module txfifo_ctrl
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoEn,
  input  logic          wrEn,
  input  logic          advance,
  input  logic          txActive,
  input  logic          clrUnderrun,
  output fifoStrobe_t   strobe,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtrNext,
  output logic          fullFlag,
  output logic          emptyFlag,
  output logic          halfEmptyFlag,
  output logic          dataAvail,
  output logic          underrunFlag
);

  localparam int HALF = DEPTH / 2;
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [PW-1:0] rdPtr;
  logic [CW-1:0] wordCnt;
  logic          isFull, isEmpty, underrunEvt, underrunQ;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign isFull  = (wordCnt == CNT_FULL);
  assign isEmpty = (wordCnt == '0);

  always_comb begin
    strobe.flush   = !fifoEn;
    strobe.doWrite = fifoEn && wrEn && !isFull;
    strobe.doRead  = fifoEn && advance && !isEmpty;
  end

  assign underrunEvt = fifoEn && advance && txActive && isEmpty;
  assign rdPtrNext   = strobe.flush  ? '0 :
                       strobe.doRead ? bump(rdPtr) : rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      wordCnt <= '0;
    end else begin
      rdPtr <= rdPtrNext;
      if (strobe.doWrite) wrPtr <= bump(wrPtr);
      case ({strobe.doWrite, strobe.doRead})
        2'b10:   wordCnt <= wordCnt + 1'b1;
        2'b01:   wordCnt <= wordCnt - 1'b1;
        default: wordCnt <= wordCnt;
      endcase
    end
  end

  // Sticky record: a new event outranks a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rstN || !fifoEn)  underrunQ <= 1'b0;
    else if (underrunEvt)  underrunQ <= 1'b1;
    else if (clrUnderrun)  underrunQ <= 1'b0;
  end

  assign fullFlag      = fifoEn && isFull;
  assign emptyFlag     = fifoEn && isEmpty;
  assign dataAvail     = fifoEn && !isEmpty;
  assign halfEmptyFlag = fifoEn && ((CNT_FULL - wordCnt) >= CNT_HALF);
  assign underrunFlag  = fifoEn && underrunQ;

endmodule

// File: rtl/txfifo_dpath.sv
module txfifo_dpath
  import txfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [PW-1:0]     wrPtr,
  input  logic [PW-1:0]     rdPtrNext,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] outWord
);

  logic [DATA_W-1:0] store [DEPTH];
  logic              bypass, reload;

  always_ff @(posedge clk) begin
    if (strobe.doWrite) store[wrPtr] <= wrData;
  end

  // A word written into the slot that becomes the head is forwarded directly
  assign bypass = strobe.doWrite && (wrPtr == rdPtrNext);
  assign reload = strobe.doWrite || strobe.doRead || strobe.flush;

  always_ff @(posedge clk) begin
    if (!rstN)       outWord <= '0;
    else if (reload) outWord <= bypass ? wrData : store[rdPtrNext];
  end

endmodule

// File: rtl/txfifo_top.sv
module txfifo_top
  import txfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              advance,
  input  logic              txActive,
  input  logic              clrUnderrun,
  output logic [DATA_W-1:0] outWord,
  output logic              fullFlag,
  output logic              emptyFlag,
  output logic              halfEmptyFlag,
  output logic              dataAvail,
  output logic              underrunFlag
);

  localparam int PW = $clog2(DEPTH);

  fifoStrobe_t   strobe;
  logic [PW-1:0] wrPtr, rdPtrNext;

  txfifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrEn(wrEn),
    .advance(advance), .txActive(txActive), .clrUnderrun(clrUnderrun),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtrNext(rdPtrNext),
    .fullFlag(fullFlag), .emptyFlag(emptyFlag), .halfEmptyFlag(halfEmptyFlag),
    .dataAvail(dataAvail), .underrunFlag(underrunFlag)
  );

  txfifo_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr),
    .rdPtrNext(rdPtrNext), .wrData(wrData), .outWord(outWord)
  );

endmodule

// File: rtl/txfifo_chk.sv
module txfifo_chk (
  input logic clk,
  input logic rstN,
  input logic fifoEn,
  input logic wrEn,
  input logic advance,
  input logic txActive,
  input logic clrUnderrun,
  input logic fullFlag,
  input logic emptyFlag,
  input logic halfEmptyFlag,
  input logic dataAvail,
  input logic underrunFlag
);

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !(fullFlag && emptyFlag)); // R3

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && $past(fifoEn && fullFlag && !advance)) |-> fullFlag); // R3

  AST_AVAIL_INVERSE: assert property (@(posedge clk) disable iff (!rstN)
    fifoEn |-> (dataAvail == !emptyFlag)); // R4

  AST_HALF_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> halfEmptyFlag); // R5

  AST_NO_HALF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> !halfEmptyFlag); // R5

  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && $past(fifoEn && advance && txActive && emptyFlag)) |-> underrunFlag); // R6

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && $past(fifoEn && underrunFlag && !clrUnderrun)) |-> underrunFlag); // R6

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> !(fullFlag || emptyFlag || halfEmptyFlag || dataAvail || underrunFlag)); // R7

  AST_EMPTY_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && $past(fifoEn && emptyFlag && !wrEn)) |-> emptyFlag); // R8

endmodule

bind txfifo_top txfifo_chk chk_i (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrEn(wrEn), .advance(advance),
  .txActive(txActive), .clrUnderrun(clrUnderrun), .fullFlag(fullFlag),
  .emptyFlag(emptyFlag), .halfEmptyFlag(halfEmptyFlag), .dataAvail(dataAvail),
  .underrunFlag(underrunFlag)
);

// File: tb/txfifo_tb.sv
`timescale 1ns/1ps
module txfifo_top_tb_top;

  localparam int DW = 32;
  localparam int NV = 14;

  // {en,wr,adv,act,clr} data exp{full,empty,half,avail,under} expOut
  localparam logic [25:0] VEC [NV] = '{
    {5'b11000, 8'h11, 5'b00110, 8'h11},
    {5'b11000, 8'h22, 5'b00110, 8'h11},
    {5'b10110, 8'h00, 5'b00110, 8'h22},
    {5'b10110, 8'h00, 5'b01100, 8'h00},
    {5'b10110, 8'h00, 5'b01101, 8'h00},
    {5'b10000, 8'h00, 5'b01101, 8'h00},
    {5'b11000, 8'h33, 5'b00111, 8'h33},
    {5'b10001, 8'h00, 5'b00110, 8'h33},
    {5'b10110, 8'h00, 5'b01100, 8'h00},
    {5'b10100, 8'h00, 5'b01100, 8'h00},
    {5'b10111, 8'h00, 5'b01101, 8'h00},
    {5'b00000, 8'h00, 5'b00000, 8'h00},
    {5'b01000, 8'h44, 5'b00000, 8'h00},
    {5'b10000, 8'h00, 5'b01100, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic fifoEn = 1'b1, wrEn = 1'b0, advance = 1'b0, txActive = 1'b0, clrUnderrun = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] outWord;
  logic fullFlag, emptyFlag, halfEmptyFlag, dataAvail, underrunFlag;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  txfifo_top #(.DEPTH(16), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrEn(wrEn), .wrData(wrData),
    .advance(advance), .txActive(txActive), .clrUnderrun(clrUnderrun),
    .outWord(outWord), .fullFlag(fullFlag), .emptyFlag(emptyFlag),
    .halfEmptyFlag(halfEmptyFlag), .dataAvail(dataAvail), .underrunFlag(underrunFlag)
  );

  function automatic logic [4:0] flags();
    return {fullFlag, emptyFlag, halfEmptyFlag, dataAvail, underrunFlag};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle from a negative edge and return at the next negative edge
  task automatic step(input logic en, input logic wr, input logic [7:0] d,
                      input logic adv, input logic act, input logic clr);
    fifoEn = en; wrEn = wr; wrData = {4{d}}; advance = adv; txActive = act; clrUnderrun = clr;
    @(negedge clk);
    wrEn = 1'b0; advance = 1'b0; clrUnderrun = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // Reset state: enabled and empty
    check("R4 reset flags", DW'(flags()), DW'(5'b01100));
    rstN = 1'b1;
    @(negedge clk);

    // Table of vectors: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][25], VEC[i][24], VEC[i][20:13], VEC[i][23], VEC[i][22], VEC[i][21]);
      check($sformatf("R4 R5 R6 R7 R8 flags vec %0d", i), DW'(flags()), DW'(VEC[i][12:8]));
      if (VEC[i][9])
        check($sformatf("R2 outWord vec %0d", i), outWord, {4{VEC[i][7:0]}});
    end

    // Fill to the half boundary and then to full (R5, R3)
    for (int i = 0; i < 16; i++) begin
      step(1, 1, 8'hA0 + 8'(i), 0, 0, 0);
      if (i == 0) check("R2 head after first write", outWord, {4{8'hA0}});
      if (i == 7) check("R5 half at 8 stored", DW'(halfEmptyFlag), 1);
      if (i == 8) check("R5 no half at 9 stored", DW'(halfEmptyFlag), 0);
      if (i == 14) check("R3 not full at 15", DW'(fullFlag), 0);
    end
    check("R3 full at 16", DW'(fullFlag), 1);
    step(1, 1, 8'hFF, 0, 0, 0);
    check("R3 still full after dropped write", DW'(fullFlag), 1);

    // Drain in order, head must advance word by word (R1, R2, R3)
    for (int i = 0; i < 16; i++) begin
      check($sformatf("R1 order word %0d", i), outWord, {4{8'hA0 + 8'(i)}});
      step(1, 0, 8'h00, 1, 1, 0);
      if (i == 0) check("R3 full clears after advance", DW'(fullFlag), 0);
    end
    check("R1 empty after drain", DW'(emptyFlag), 1);
    check("R6 no underrun after exact drain", DW'(underrunFlag), 0);

    // Simultaneous write and advance (R2)
    step(1, 1, 8'hB1, 0, 0, 0);
    step(1, 1, 8'hB2, 1, 1, 0);
    check("R2 write+advance head", outWord, {4{8'hB2}});
    check("R2 write+advance count stays one", DW'({emptyFlag, dataAvail}), DW'(2'b01));
    step(1, 0, 8'h00, 1, 1, 0);
    check("R8 empty after last advance", DW'(emptyFlag), 1);

    // Disable with data, then re-enable (R7)
    for (int i = 0; i < 3; i++) step(1, 1, 8'hC0 + 8'(i), 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0);
    check("R7 flags low while disabled", DW'(flags()), 0);
    step(1, 1, 8'hD0, 0, 0, 0);
    check("R7 pointers reset on re-enable", outWord, {4{8'hD0}});
    check("R7 single word after re-enable", DW'(flags()), DW'(5'b00110));

    done = 1;
    finishRun();
  end

endmodule